// File: doc/BRIEF.md
# Shared Bus Arbiter and Decoder Interconnect

This block joins a parameterised group of bus masters to a parameterised group of slaves over one shared pipelined bus of the AHB style. A fixed-priority arbiter picks the owner of the address bus. A decoder turns the top address bits into a slave select. Two multiplexers steer traffic in opposite directions. One carries the address, control and write data from the masters to the slaves. The other carries read data, the ready signal and the response from the slaves back to the masters.

The grant is registered, and so is the index of the owning master. The write-data multiplexer and the read-side multiplexer follow copies of the master and slave selects that are delayed by one accepted transfer. This lets the data phase of one master overlap the address phase of the next. Wait states from a slave stall the whole bus, including any change of ownership. ERROR and SPLIT responses travel back unchanged.

Top module: `shared_bus_ic`

## Requirements
- R1: While rst_ni is low, every output is zero whatever the inputs are, including the grant, master index, slave selects, address, write data, ready, read data and response.
- R2: Grant and master index are registered and change only at a clock edge. When no master requests, master 0 holds the grant. The master index always names the granted master.
- R3: Arbitration is fixed priority, and the lowest-numbered requesting master wins. At most one grant bit is high.
- R4: Grant and master index change only at an edge where the bus ready output is high. While a slave holds ready low, ownership stays frozen.
- R5: The slave index is the top ceil(log2(N_SLV)) address bits read as a binary number. With two slaves, address bit AW-1 = 1 selects slave 1 (s_hsel_o = 2'b10) and 0 selects slave 0. At most one select is high.
- R6: Address, transfer type, direction, size and burst on the slave side come from the master named by the current master index.
- R7: Write data on the slave side comes from the master that owned the address bus at the last edge with ready high. A new owner can drive addresses while the previous owner drives write data.
- R8: Read data, ready and response to the masters come from the slave addressed at the last edge with ready high.
- R9: Response codes pass back unchanged: OKAY=00, ERROR=01, RETRY=10, SPLIT=11.
- R10: When the previous address phase was IDLE (transfer type 00) or BUSY (01), the masters see ready high and OKAY regardless of the slave inputs. NONSEQ is 10 and SEQ is 11.
- R11: With a single master, that master holds the grant without requesting, its index is 0, and decode and data steering behave as in R5 to R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| m_busreq_i | input | N_MST | Bus request, one bit per master |
| m_haddr_i | input | N_MST*AW | Addresses, master i at bits [i*AW +: AW] |
| m_htrans_i | input | N_MST*2 | Transfer types, 2 bits per master |
| m_hwrite_i | input | N_MST | Write direction, one bit per master |
| m_hsize_i | input | N_MST*3 | Transfer sizes, 3 bits per master |
| m_hburst_i | input | N_MST*3 | Burst types, 3 bits per master |
| m_hwdata_i | input | N_MST*DW | Write data, DW bits per master |
| m_hgrant_o | output | N_MST | One-hot grant |
| m_hrdata_o | output | DW | Read data to masters |
| m_hready_o | output | 1 | Bus ready to masters and slaves |
| m_hresp_o | output | 2 | Response to masters |
| hmaster_o | output | MW | Index of the address-bus owner |
| s_hsel_o | output | N_SLV | Slave selects |
| s_haddr_o | output | AW | Address to slaves |
| s_htrans_o | output | 2 | Transfer type to slaves |
| s_hwrite_o | output | 1 | Direction to slaves |
| s_hsize_o | output | 3 | Size to slaves |
| s_hburst_o | output | 3 | Burst type to slaves |
| s_hwdata_o | output | DW | Write data to slaves |
| s_hrdata_i | input | N_SLV*DW | Read data, DW bits per slave |
| s_hready_i | input | N_SLV | Ready out of each slave |
| s_hresp_i | input | N_SLV*2 | Response, 2 bits per slave |

## Verification
Grant and master index appear one edge after the request pattern is applied. Address, control and slave selects follow that index in the same cycle. Write data, read data, ready and response belong to the transfer accepted at the previous ready edge. The bench therefore applies stimulus just after an edge and checks the combinational paths a fraction of a cycle later. It checks the registered results only after the next edge, and across a ready-low stall it also checks that nothing moved after each stalled edge.

// File: rtl/ahb_ic_pkg.sv
package ahb_ic_pkg;
  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_BUSY   = 2'b01;
  localparam logic [1:0] TR_NONSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ    = 2'b11;

  localparam logic [1:0] RS_OKAY  = 2'b00;
  localparam logic [1:0] RS_ERROR = 2'b01;
  localparam logic [1:0] RS_RETRY = 2'b10;
  localparam logic [1:0] RS_SPLIT = 2'b11;

  function automatic int idx_bits(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ic_arbiter.sv
module ic_arbiter #(
  parameter int N_MST = 2,
  parameter int MW    = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_MST-1:0] busreq_i,
  input  logic             ready_i,
  output logic [N_MST-1:0] grant_o,
  output logic [MW-1:0]    amaster_o,
  output logic [MW-1:0]    dmaster_o
);
  logic [MW-1:0]    pick;
  logic [N_MST-1:0] nxt_grant;
  logic [N_MST-1:0] grant_q;
  logic [MW-1:0]    amaster_q;
  logic [MW-1:0]    dmaster_q;

  // scan from the top so the lowest requester wins; no request -> master 0
  always_comb begin
    pick = '0;
    for (int i = N_MST - 1; i >= 0; i--) begin
      if (busreq_i[i]) pick = MW'(i);
    end
  end

  for (genvar g = 0; g < N_MST; g++) begin : g_oh
    assign nxt_grant[g] = (pick == MW'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_q   <= '0;
      amaster_q <= '0;
      dmaster_q <= '0;
    end else if (ready_i) begin
      grant_q   <= nxt_grant;
      amaster_q <= pick;
      dmaster_q <= amaster_q;
    end
  end

  assign grant_o   = grant_q;
  assign amaster_o = amaster_q;
  assign dmaster_o = dmaster_q;
endmodule

// File: rtl/ic_decoder.sv
module ic_decoder #(
  parameter int N_SLV = 2,
  parameter int SW    = 1
) (
  input  logic [SW-1:0]    top_bits_i,
  output logic [N_SLV-1:0] hsel_o,
  output logic [SW-1:0]    idx_o,
  output logic             hit_o
);
  if (N_SLV == 1) begin : g_single
    assign idx_o = (top_bits_i == top_bits_i) ? '0 : '0;
  end else begin : g_multi
    assign idx_o = top_bits_i;
  end

  for (genvar g = 0; g < N_SLV; g++) begin : g_sel
    assign hsel_o[g] = (idx_o == SW'(g));
  end

  // an index past the last slave selects nobody
  assign hit_o = |hsel_o;
endmodule

// File: rtl/ic_mst_mux.sv
module ic_mst_mux #(
  parameter int N_MST = 2,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int MW    = 1
) (
  input  logic [N_MST*AW-1:0] haddr_i,
  input  logic [N_MST*2-1:0]  htrans_i,
  input  logic [N_MST-1:0]    hwrite_i,
  input  logic [N_MST*3-1:0]  hsize_i,
  input  logic [N_MST*3-1:0]  hburst_i,
  input  logic [N_MST*DW-1:0] hwdata_i,
  input  logic [MW-1:0]       amaster_i,
  input  logic [MW-1:0]       dmaster_i,
  output logic [AW-1:0]       haddr_o,
  output logic [1:0]          htrans_o,
  output logic                hwrite_o,
  output logic [2:0]          hsize_o,
  output logic [2:0]          hburst_o,
  output logic [DW-1:0]       hwdata_o
);
  always_comb begin
    haddr_o  = '0;
    htrans_o = '0;
    hwrite_o = 1'b0;
    hsize_o  = '0;
    hburst_o = '0;
    for (int i = 0; i < N_MST; i++) begin
      if (amaster_i == MW'(i)) begin
        haddr_o  = haddr_i[i*AW +: AW];
        htrans_o = htrans_i[i*2 +: 2];
        hwrite_o = hwrite_i[i];
        hsize_o  = hsize_i[i*3 +: 3];
        hburst_o = hburst_i[i*3 +: 3];
      end
    end
  end

  always_comb begin
    hwdata_o = '0;
    for (int i = 0; i < N_MST; i++) begin
      if (dmaster_i == MW'(i)) hwdata_o = hwdata_i[i*DW +: DW];
    end
  end
endmodule

// File: rtl/ic_slv_mux.sv
module ic_slv_mux import ahb_ic_pkg::*; #(
  parameter int N_SLV = 2,
  parameter int DW    = 32,
  parameter int SW    = 1
) (
  input  logic [N_SLV*DW-1:0] hrdata_i,
  input  logic [N_SLV-1:0]    hready_i,
  input  logic [N_SLV*2-1:0]  hresp_i,
  input  logic [SW-1:0]       dslave_i,
  input  logic                dvalid_i,
  output logic [DW-1:0]       hrdata_o,
  output logic                hready_o,
  output logic [1:0]          hresp_o
);
  always_comb begin
    hrdata_o = '0;
    hready_o = 1'b1;
    hresp_o  = RS_OKAY;
    for (int i = 0; i < N_SLV; i++) begin
      if (dslave_i == SW'(i)) begin
        hrdata_o = hrdata_i[i*DW +: DW];
        // idle data phase completes at once with OKAY
        if (dvalid_i) begin
          hready_o = hready_i[i];
          hresp_o  = hresp_i[i*2 +: 2];
        end
      end
    end
  end
endmodule

// File: rtl/shared_bus_ic.sv
module shared_bus_ic import ahb_ic_pkg::*; #(
  parameter int N_MST = 2,
  parameter int N_SLV = 2,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int MW   = idx_bits(N_MST),
  localparam int SW   = idx_bits(N_SLV)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_MST-1:0]    m_busreq_i,
  input  logic [N_MST*AW-1:0] m_haddr_i,
  input  logic [N_MST*2-1:0]  m_htrans_i,
  input  logic [N_MST-1:0]    m_hwrite_i,
  input  logic [N_MST*3-1:0]  m_hsize_i,
  input  logic [N_MST*3-1:0]  m_hburst_i,
  input  logic [N_MST*DW-1:0] m_hwdata_i,
  output logic [N_MST-1:0]    m_hgrant_o,
  output logic [DW-1:0]       m_hrdata_o,
  output logic                m_hready_o,
  output logic [1:0]          m_hresp_o,
  output logic [MW-1:0]       hmaster_o,
  output logic [N_SLV-1:0]    s_hsel_o,
  output logic [AW-1:0]       s_haddr_o,
  output logic [1:0]          s_htrans_o,
  output logic                s_hwrite_o,
  output logic [2:0]          s_hsize_o,
  output logic [2:0]          s_hburst_o,
  output logic [DW-1:0]       s_hwdata_o,
  input  logic [N_SLV*DW-1:0] s_hrdata_i,
  input  logic [N_SLV-1:0]    s_hready_i,
  input  logic [N_SLV*2-1:0]  s_hresp_i
);
  logic [N_MST-1:0] grant;
  logic [MW-1:0]    addr_master;
  logic [MW-1:0]    data_master;
  logic             bus_ready;
  logic [AW-1:0]    haddr;
  logic [1:0]       htrans;
  logic             hwrite;
  logic [2:0]       hsize;
  logic [2:0]       hburst;
  logic [DW-1:0]    hwdata;
  logic [N_SLV-1:0] hsel;
  logic [SW-1:0]    sel_idx;
  logic             sel_hit;
  logic [SW-1:0]    data_slave;
  logic             data_valid;
  logic [DW-1:0]    hrdata;
  logic [1:0]       hresp;

  ic_arbiter #(.N_MST(N_MST), .MW(MW)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .busreq_i  (m_busreq_i),
    .ready_i   (bus_ready),
    .grant_o   (grant),
    .amaster_o (addr_master),
    .dmaster_o (data_master)
  );

  ic_mst_mux #(.N_MST(N_MST), .AW(AW), .DW(DW), .MW(MW)) u_mmux (
    .haddr_i   (m_haddr_i),
    .htrans_i  (m_htrans_i),
    .hwrite_i  (m_hwrite_i),
    .hsize_i   (m_hsize_i),
    .hburst_i  (m_hburst_i),
    .hwdata_i  (m_hwdata_i),
    .amaster_i (addr_master),
    .dmaster_i (data_master),
    .haddr_o   (haddr),
    .htrans_o  (htrans),
    .hwrite_o  (hwrite),
    .hsize_o   (hsize),
    .hburst_o  (hburst),
    .hwdata_o  (hwdata)
  );

  ic_decoder #(.N_SLV(N_SLV), .SW(SW)) u_dec (
    .top_bits_i (haddr[AW-1 -: SW]),
    .hsel_o     (hsel),
    .idx_o      (sel_idx),
    .hit_o      (sel_hit)
  );

  // data-phase slave tracks the address phase accepted at each ready edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_slave <= '0;
      data_valid <= 1'b0;
    end else if (bus_ready) begin
      data_slave <= sel_idx;
      data_valid <= sel_hit & htrans[1];
    end
  end

  ic_slv_mux #(.N_SLV(N_SLV), .DW(DW), .SW(SW)) u_smux (
    .hrdata_i (s_hrdata_i),
    .hready_i (s_hready_i),
    .hresp_i  (s_hresp_i),
    .dslave_i (data_slave),
    .dvalid_i (data_valid),
    .hrdata_o (hrdata),
    .hready_o (bus_ready),
    .hresp_o  (hresp)
  );

  // all outputs held at zero while reset is low
  assign m_hgrant_o = rst_ni ? grant       : '0;
  assign hmaster_o  = rst_ni ? addr_master : '0;
  assign m_hrdata_o = rst_ni ? hrdata      : '0;
  assign m_hready_o = rst_ni & bus_ready;
  assign m_hresp_o  = rst_ni ? hresp       : RS_OKAY;
  assign s_hsel_o   = rst_ni ? hsel        : '0;
  assign s_haddr_o  = rst_ni ? haddr       : '0;
  assign s_htrans_o = rst_ni ? htrans      : TR_IDLE;
  assign s_hwrite_o = rst_ni & hwrite;
  assign s_hsize_o  = rst_ni ? hsize       : '0;
  assign s_hburst_o = rst_ni ? hburst      : '0;
  assign s_hwdata_o = rst_ni ? hwdata      : '0;
endmodule

// File: rtl/shared_bus_ic_chk.sv
module shared_bus_ic_chk import ahb_ic_pkg::*; #(
  parameter int N_MST = 2,
  parameter int N_SLV = 2,
  localparam int MW   = idx_bits(N_MST)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_MST-1:0] m_hgrant_o,
  input logic [MW-1:0]    hmaster_o,
  input logic             m_hready_o,
  input logic [N_SLV-1:0] s_hsel_o,
  input logic [1:0]       s_htrans_o,
  input logic [MW-1:0]    data_master
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(m_hgrant_o)); // R3

  AST_GRANT_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|m_hgrant_o) |-> m_hgrant_o[hmaster_o]); // R2

  AST_GRANT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !m_hready_o |=> ($stable(m_hgrant_o) && $stable(hmaster_o))); // R4

  AST_DATA_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_hready_o |=> (data_master == $past(hmaster_o))); // R7

  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(s_hsel_o)); // R5

  AST_IDLE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_hready_o && !s_htrans_o[1]) |=> m_hready_o); // R10
endmodule

bind shared_bus_ic shared_bus_ic_chk #(.N_MST(N_MST), .N_SLV(N_SLV)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .m_hgrant_o  (m_hgrant_o),
  .hmaster_o   (hmaster_o),
  .m_hready_o  (m_hready_o),
  .s_hsel_o    (s_hsel_o),
  .s_htrans_o  (s_htrans_o),
  .data_master (data_master)
);

// File: tb/sim_shared_bus_ic.sv
`timescale 1ns/100ps
module sim_shared_bus_ic;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  int   n_chk = 0;
  int   n_err = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  // u0: two masters, two slaves
  logic [1:0]  busreq;
  logic [63:0] haddr;
  logic [3:0]  htrans;
  logic [1:0]  hwrite;
  logic [5:0]  hsize, hburst;
  logic [63:0] hwdata;
  logic [1:0]  grant;
  logic [31:0] rdata;
  logic        ready;
  logic [1:0]  resp;
  logic [0:0]  hmaster;
  logic [1:0]  hsel;
  logic [31:0] s_addr, s_wdata;
  logic [1:0]  s_trans;
  logic        s_write;
  logic [2:0]  s_size, s_burst;
  logic [63:0] s_rdata;
  logic [1:0]  s_ready;
  logic [3:0]  s_resp;

  shared_bus_ic u0 (
    .clk_i(clk), .rst_ni(rst_ni), .m_busreq_i(busreq), .m_haddr_i(haddr),
    .m_htrans_i(htrans), .m_hwrite_i(hwrite), .m_hsize_i(hsize), .m_hburst_i(hburst),
    .m_hwdata_i(hwdata), .m_hgrant_o(grant), .m_hrdata_o(rdata), .m_hready_o(ready),
    .m_hresp_o(resp), .hmaster_o(hmaster), .s_hsel_o(hsel), .s_haddr_o(s_addr),
    .s_htrans_o(s_trans), .s_hwrite_o(s_write), .s_hsize_o(s_size), .s_hburst_o(s_burst),
    .s_hwdata_o(s_wdata), .s_hrdata_i(s_rdata), .s_hready_i(s_ready), .s_hresp_i(s_resp)
  );

  // u1: one master, two slaves
  logic [0:0]  b_req;
  logic [31:0] b_addr, b_wdata, b_rdata, b_saddr, b_swdata;
  logic [1:0]  b_trans, b_resp, b_hsel, b_strans;
  logic [0:0]  b_write, b_grant, b_master;
  logic [2:0]  b_size, b_burst, b_ssize, b_sburst;
  logic        b_ready, b_swrite;

  shared_bus_ic #(.N_MST(1)) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .m_busreq_i(b_req), .m_haddr_i(b_addr),
    .m_htrans_i(b_trans), .m_hwrite_i(b_write), .m_hsize_i(b_size), .m_hburst_i(b_burst),
    .m_hwdata_i(b_wdata), .m_hgrant_o(b_grant), .m_hrdata_o(b_rdata), .m_hready_o(b_ready),
    .m_hresp_o(b_resp), .hmaster_o(b_master), .s_hsel_o(b_hsel), .s_haddr_o(b_saddr),
    .s_htrans_o(b_strans), .s_hwrite_o(b_swrite), .s_hsize_o(b_ssize), .s_hburst_o(b_sburst),
    .s_hwdata_o(b_swdata), .s_hrdata_i(s_rdata), .s_hready_i(s_ready), .s_hresp_i(s_resp)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic drive_m(int i, logic [31:0] a, logic [1:0] t, logic w, logic [31:0] d);
    haddr[i*32 +: 32] = a;
    htrans[i*2 +: 2]  = t;
    hwrite[i]         = w;
    hwdata[i*32 +: 32] = d;
  endtask

  task automatic t_reset();
    busreq = 2'b11; haddr = '1; htrans = 4'b1010; hwrite = 2'b11;
    hsize = '1; hburst = '1; hwdata = '1;
    s_rdata = '1; s_ready = 2'b11; s_resp = 4'b0101;
    b_req = 1'b1; b_addr = '1; b_trans = 2'b10; b_write = 1'b1;
    b_size = '1; b_burst = '1; b_wdata = '1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 grant", grant, 0);
    check("R1 hmaster", hmaster, 0);
    check("R1 hsel", hsel, 0);
    check("R1 addr", s_addr, 0);
    check("R1 wdata", s_wdata, 0);
    check("R1 ready/resp/rdata", {ready, resp, rdata}, 0);
    check("R1 single-master grant", b_grant, 0);
    busreq = 2'b00; htrans = '0; hwrite = '0; hsize = '0; hburst = '0; hwdata = '0;
    haddr = '0; s_rdata = '0; s_resp = '0;
    b_req = 1'b0; b_trans = '0; b_addr = '0; b_wdata = '0; b_write = 1'b0;
    b_size = '0; b_burst = '0;
    @(negedge clk);
    rst_ni = 1'b1;
    step();
    check("R2 default grant", grant, 2'b01);
    check("R2 default hmaster", hmaster, 0);
  endtask

  task automatic t_priority();
    busreq = 2'b11;
    step();
    check("R3 both request", grant, 2'b01);
    busreq = 2'b10;
    #0.5;
    check("R2 grant registered", grant, 2'b01);
    step();
    check("R3 master1 alone", grant, 2'b10);
    check("R2 hmaster follows grant", hmaster, 1);
    busreq = 2'b01;
    step();
    check("R3 back to master0", grant, 2'b01);
  endtask

  task automatic t_pipeline();
    drive_m(0, 32'h0000_0040, 2'b10, 1'b1, 32'h1111_0000);
    drive_m(1, 32'h8000_0080, 2'b00, 1'b1, 32'h2222_0000);
    busreq = 2'b10;
    #0.5;
    check("R5 low address to slave0", hsel, 2'b01);
    check("R6 address from master0", s_addr, 32'h0000_0040);
    check("R6 trans from master0", s_trans, 2'b10);
    step();
    drive_m(0, 32'h0000_0040, 2'b00, 1'b0, 32'h1111_0000);
    drive_m(1, 32'h8000_0080, 2'b10, 1'b1, 32'h2222_0000);
    hburst[5:3] = 3'b011;
    s_rdata = {32'hBBBB_0000, 32'hAAAA_0000};
    s_resp  = 4'b0001;
    #0.5;
    check("R6 address from master1", s_addr, 32'h8000_0080);
    check("R6 burst from master1", s_burst, 3'b011);
    check("R5 high address to slave1", hsel, 2'b10);
    check("R7 wdata from previous owner", s_wdata, 32'h1111_0000);
    check("R8 rdata from slave0", rdata, 32'hAAAA_0000);
    check("R9 ERROR passes", resp, 2'b01);
    step();
    drive_m(1, 32'h8000_0080, 2'b00, 1'b0, 32'h2222_0000);
    s_resp  = 4'b1100;
    s_ready = 2'b01;
    busreq  = 2'b01;
    #0.5;
    check("R7 wdata from master1", s_wdata, 32'h2222_0000);
    check("R9 SPLIT passes", resp, 2'b11);
    check("R8 ready from slave1", ready, 1'b0);
    check("R8 rdata from slave1", rdata, 32'hBBBB_0000);
  endtask

  task automatic t_stall();
    step();
    check("R4 grant frozen", grant, 2'b10);
    step();
    check("R4 grant still frozen", {grant, hmaster}, {2'b10, 1'b1});
    s_ready = 2'b11;
    s_resp  = 4'b0000;
    #0.5;
    check("R8 ready released", ready, 1'b1);
    step();
    check("R4 grant moves after ready", {grant, hmaster}, {2'b01, 1'b0});
    s_ready = 2'b00;
    s_resp  = 4'b0101;
    #0.5;
    check("R10 idle phase ready", ready, 1'b1);
    check("R10 idle phase okay", resp, 2'b00);
    s_ready = 2'b11;
    s_resp  = 4'b0000;
  endtask

  task automatic t_single();
    check("R11 grant without request", b_grant, 1'b1);
    check("R11 master index", b_master, 1'b0);
    b_addr = 32'h8000_0004; b_trans = 2'b10; b_write = 1'b1; b_wdata = 32'h5A5A_0001;
    s_rdata = {32'hCCCC_0001, 32'hDDDD_0000};
    #0.5;
    check("R11 decode slave1", b_hsel, 2'b10);
    check("R11 address", b_saddr, 32'h8000_0004);
    step();
    b_trans = 2'b00;
    #0.5;
    check("R11 write data", b_swdata, 32'h5A5A_0001);
    check("R11 read data slave1", b_rdata, 32'hCCCC_0001);
  endtask

  initial begin
    t_reset();
    t_priority();
    t_pipeline();
    t_stall();
    t_single();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule